// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers single-cycle event pulses from the internal engines of a network controller (host error, transmit and receive completion, flow-control frame arrival, link change, DMA completion, statistics update, software request and an auxiliary line). Each pulse is held in a sticky status bit. A per-source enable mask selects which pending bits may raise the one active-low interrupt line towards the host.

Software reaches the block through a simple synchronous 16-bit register port. Reads are combinational from the current state. Writes and side effects take place at the next rising clock edge. Three locations are decoded:

- an enable word;
- a status word whose source bits are write-one-to-clear;
- an acknowledge alias that returns the status and wipes the whole enable mask.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable word and every status bit are 0, and `irq_n` is 1.
- R2: The enable word is at offset 0x4C. Bits 1 to 11 are stored as written, including bit 5, which has no source. Bits 0 and 12 to 15 always read 0 and ignore writes.
- R3: A pulse on `evt_i[k]` sets status bit k at the next clock edge, whatever the enable value. This applies to k = 1, 2, 3, 4, 6, 7, 8, 9, 10 and 11 (host error, tx done, control frame, rx done, software request, stats, link, tx DMA, rx DMA, auxiliary). A set bit stays set until software clears it.
- R4: Status bit 0, read at offset 0x4E, is the OR over all bits of (status AND enable), evaluated from the current state.
- R5: `irq_n` is 0 exactly when that OR is 1. It is registered, so it follows a state change one clock later.
- R6: Writing 1 to a status source bit clears it. Writing 0 leaves it alone. Writes to status bit 0 and to bits without a source have no effect.
- R7: If a pulse and a clearing write hit the same status bit in the same cycle, the bit ends up 1.
- R8: A read at offset 0x5A returns the status word as it stood before the read, bit 0 included. At the next edge the whole enable word becomes 0.
- R9: Reads of any other offset return 0, and writes to them change nothing.
- R10: Pulses on `evt_i` bits 0, 5 and 12 to 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 16 | Event pulses, one bit per status position |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (acknowledge side effect) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from current state |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
A status bit wrongly held or lost shows on the very next status read. If it is enabled, it also shows on `irq_n` one clock after the state goes wrong. A corrupted enable bit stays hidden while nothing is pending at that position. It shows only when a matching event arrives or when the enable word is read back. For that reason the tests pulse every source with the mask both open and closed. The acknowledge read is checked on both sides: the value it returns before the clear, and the empty enable word and released interrupt line that follow.

// File: rtl/irq_pkg.sv
// Package: shared widths, register offsets and bit masks for the interrupt unit.
package irq_pkg;
    localparam int          DATA_W     = 16;
    localparam int          ADDR_W     = 8;
    localparam logic [7:0]  OFS_ENABLE = 8'h4C;
    localparam logic [7:0]  OFS_STATUS = 8'h4E;
    localparam logic [7:0]  OFS_ACK    = 8'h5A;
    // positions that own an event source
    localparam logic [15:0] SRC_MASK   = 16'h0FDE;
    // positions stored in the enable word
    localparam logic [15:0] ENA_MASK   = 16'h0FFE;
endpackage

// File: rtl/irq_status_bank.sv
// Sticky status bits. Each masked position is set by its event pulse and
// cleared by a write-one-to-clear strobe; set has priority over clear.
// Assumes clr_i is already qualified by a write to the status offset.
module irq_status_bank #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] stat_d;

    // next state: keep bits not cleared, then OR in new events, restrict to sources
    always_comb begin
        stat_d = ((stat_q & ~clr_i) | evt_i) & MASK;
    end

    // state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_enable_reg.sv
// Enable mask register. Only positions in MASK are stored. A clear-all
// strobe (acknowledge read) has priority over a write in the same cycle.
module irq_enable_reg #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         clr_all_i,
    output logic [W-1:0] ena_o
);
    logic [W-1:0] ena_q;

    // mask storage: clear-all first, then write, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)         ena_q <= '0;
        else if (clr_all_i) ena_q <= '0;
        else if (wr_i)      ena_q <= wdata_i & MASK;
    end

    assign ena_o = ena_q;
endmodule

// File: rtl/irq_read_mux.sv
// Read data selection. Purely combinational; unmapped offsets give zero.
// The status and acknowledge offsets return the same word.
module irq_read_mux #(
    parameter int                 W       = 16,
    parameter int                 AW      = 8,
    parameter logic [AW-1:0]      A_ENA   = '0,
    parameter logic [AW-1:0]      A_STAT  = '0,
    parameter logic [AW-1:0]      A_ACK   = '0
) (
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  ena_i,
    input  logic [W-1:0]  stat_word_i,
    output logic [W-1:0]  rdata_o
);
    // decode the offset into a read value
    always_comb begin
        if (addr_i == A_ENA)                          rdata_o = ena_i;
        else if (addr_i == A_STAT || addr_i == A_ACK) rdata_o = stat_word_i;
        else                                          rdata_o = '0;
    end
endmodule

// File: rtl/irq_aggregator.sv
// Top of the interrupt status and enable unit. Latches event pulses into
// sticky status bits, gates them with the enable mask and drives one
// registered active-low interrupt. Assumes events are single-cycle pulses
// synchronous to clk and register accesses are one cycle long.
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int                 W       = DATA_W,
    parameter int                 AW      = ADDR_W,
    parameter logic [AW-1:0]      A_ENA   = OFS_ENABLE,
    parameter logic [AW-1:0]      A_STAT  = OFS_STATUS,
    parameter logic [AW-1:0]      A_ACK   = OFS_ACK,
    parameter logic [W-1:0]       S_MASK  = SRC_MASK,
    parameter logic [W-1:0]       E_MASK  = ENA_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  evt_i,
    input  logic          reg_wr_en,
    input  logic          reg_rd_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic          irq_n
);
    localparam logic [W-1:0] BIT0 = W'(1);

    logic [W-1:0] stat_q;
    logic [W-1:0] ena_q;
    logic [W-1:0] stat_clr;
    logic [W-1:0] stat_word;
    logic         wr_ena;
    logic         ack_rd;
    logic         pend_any;
    logic         irq_n_q;

    // access decode
    always_comb begin
        wr_ena   = reg_wr_en && (reg_addr == A_ENA);
        ack_rd   = reg_rd_en && (reg_addr == A_ACK);
        stat_clr = (reg_wr_en && (reg_addr == A_STAT)) ? reg_wdata : '0;
    end

    irq_status_bank #(.W(W), .MASK(S_MASK)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (stat_clr),
        .stat_o (stat_q)
    );

    irq_enable_reg #(.W(W), .MASK(E_MASK)) u_ena (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ena),
        .wdata_i   (reg_wdata),
        .clr_all_i (ack_rd),
        .ena_o     (ena_q)
    );

    // live summary and the readable status word with summary in bit 0
    always_comb begin
        pend_any  = |(stat_q & ena_q);
        stat_word = (stat_q & ~BIT0) | (pend_any ? BIT0 : '0);
    end

    irq_read_mux #(.W(W), .AW(AW), .A_ENA(A_ENA), .A_STAT(A_STAT), .A_ACK(A_ACK)) u_rmux (
        .addr_i      (reg_addr),
        .ena_i       (ena_q),
        .stat_word_i (stat_word),
        .rdata_o     (reg_rdata)
    );

    // registered interrupt line, low while something enabled is pending
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~pend_any;
    end

    assign irq_n = irq_n_q;
endmodule

// File: rtl/irq_aggregator_checker.sv
// Property checker for irq_aggregator, attached by bind below.
module irq_aggregator_checker
    import irq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] evt_i,
    input logic        reg_wr_en,
    input logic        reg_rd_en,
    input logic [7:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        irq_n,
    input logic [15:0] stat_q,
    input logic [15:0] ena_q
);
    // R5: line follows the previous cycle's enabled-pending state
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !$past(|(stat_q & ena_q)));

    // R8: acknowledge read empties the enable word
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == OFS_ACK) |=> (ena_q == 16'h0000));

    // R3: every sourced event lands in status
    assert_event_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & SRC_MASK) != 16'h0000) |=> ((stat_q & $past(evt_i & SRC_MASK)) == $past(evt_i & SRC_MASK)));

    // R10: unsourced positions never become set
    assert_no_stray_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~SRC_MASK) == 16'h0000);

    // R2: enable read never shows reserved bits
    assert_ena_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_ENABLE) |-> ((reg_rdata & ~ENA_MASK) == 16'h0000));

    // R6: clearing write with no event drops the bits
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_STATUS && evt_i == 16'h0000) |=> ((stat_q & $past(reg_wdata)) == 16'h0000));

    // R9: unmapped offsets read zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_ENABLE && reg_addr != OFS_STATUS && reg_addr != OFS_ACK) |-> (reg_rdata == 16'h0000));
endmodule

bind irq_aggregator irq_aggregator_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .stat_q    (stat_q),
    .ena_q     (ena_q)
);

// File: tb/irq_aggregator_bench.sv
// Directed bench for irq_aggregator: one task per scenario.
module irq_aggregator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [7:0] A_ENA = 8'h4C, A_STAT = 8'h4E, A_ACK = 8'h5A;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d, logic [15:0] ev = '0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; evt_i = ev;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; evt_i = '0; reg_addr = 8'h00;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd_en = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic pulse(logic [15:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(posedge clk); #1;
        evt_i = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(A_ENA, v);  check("R1 enable", v, 16'h0000);
        rd(A_STAT, v); check("R1 status", v, 16'h0000);
        check("R1 irq_n", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_enable_bits();
        logic [15:0] v;
        wr(A_ENA, 16'hFFFF);
        rd(A_ENA, v); check("R2 writable mask", v, 16'h0FFE);
        wr(A_ENA, 16'h0020);
        rd(A_ENA, v); check("R2 bit5 stored", v, 16'h0020);
        wr(A_ENA, 16'h0000);
    endtask

    task automatic t_events_masked();
        logic [15:0] v;
        pulse(16'hFFFF);
        rd(A_STAT, v); check("R3 R10 sticky map, disabled", v, 16'h0FDE);
        tick();
        check("R5 no irq while disabled", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_irq_timing();
        logic [15:0] v;
        wr(A_ENA, 16'h0100);
        check("R5 irq registered one cycle", {15'd0, irq_n}, 16'h0001);
        tick();
        check("R5 irq low", {15'd0, irq_n}, 16'h0000);
        rd(A_STAT, v); check("R4 summary bit", v, 16'h0FDF);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        wr(A_STAT, 16'h0101);
        rd(A_STAT, v); check("R6 w1c, bit0 ignored", v, 16'h0EDE);
        tick();
        check("R5 irq released", {15'd0, irq_n}, 16'h0001);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); check("R6 zero write no effect", v, 16'h0EDE);
        wr(A_STAT, 16'hF020);
        rd(A_STAT, v); check("R6 unassigned write no effect", v, 16'h0EDE);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        wr(A_STAT, 16'h0006, 16'h0004);
        rd(A_STAT, v); check("R7 set beats clear", v, 16'h0EDC);
    endtask

    task automatic t_ack();
        logic [15:0] v;
        wr(A_ENA, 16'h0004);
        tick();
        check("R5 irq low again", {15'd0, irq_n}, 16'h0000);
        rd(A_ACK, v); check("R8 ack returns pre-clear status", v, 16'h0EDD);
        rd(A_ENA, v); check("R8 enables cleared", v, 16'h0000);
        rd(A_STAT, v); check("R8 status kept", v, 16'h0EDC);
        tick();
        check("R8 irq released", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        wr(8'h50, 16'hFFFF);
        rd(8'h50, v);  check("R9 unmapped read", v, 16'h0000);
        rd(A_ENA, v);  check("R9 unmapped write ignored (enable)", v, 16'h0000);
        rd(A_STAT, v); check("R9 unmapped write ignored (status)", v, 16'h0EDC);
        wr(A_STAT, 16'hFFFF);
        pulse(16'hF021);
        rd(A_STAT, v); check("R10 unsourced events ignored", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_enable_bits();
        t_events_masked();
        t_irq_timing();
        t_w1c();
        t_set_wins();
        t_ack();
        t_unmapped();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule